// File: doc/BRIEF.md
# Clock-Manager Lock Watchdog Reset

This block keeps a clock manager (a DCM or PLL) from staying unlocked forever. It runs on a reference clock that is always present and never comes from a clock-manager output. Two status signals from the manager are brought into that clock domain: the lock indication and the indication that the manager's input clock is present. While both are good, an internal counter is held at zero. When either one is bad, the counter counts up. When the counter enters the top few counts of its range, the block drives a reset pulse to the clock manager.

The counter does not stop at its maximum. It wraps to zero and counts again. A manager whose input clock started late, or stopped and came back, is therefore reset again and again until it reports lock. The counter width sets the retry period and must leave the manager time to lock between two pulses. The pulse length, counted in reference cycles, must be at least three cycles of the manager's input clock. A sticky flag shows that at least one recovery reset has been issued since the block was last reset.

Top module: `clkmgr_lock_watchdog`

## Requirements
- R1: While the synchronized lock and clock-present inputs are both 1, the counter stays at zero and `mgr_rst` stays 0 for any length of time.
- R2: If either synchronized input is 0, the counter advances by one per reference cycle. Lock alone being 1, or clock-present alone being 1, does not stop it.
- R3: `mgr_rst` is 1 while the counter value seen in the previous cycle lies in the top `RST_CYC` values of its `CNT_W`-bit range. From the first counting edge, `mgr_rst` first reads 1 after 2^CNT_W - RST_CYC + 1 edges and stays 1 for exactly `RST_CYC` cycles.
- R4: The counter wraps from its maximum to zero rather than saturating. While the manager stays unhealthy, pulses repeat every 2^CNT_W reference cycles.
- R5: Each status input passes through two flip-flops before use. When a healthy manager loses lock, `mgr_rst` first reads 1 on the (2^CNT_W - RST_CYC + 3)th edge after the change.
- R6: `reset_seen` rises together with the first `mgr_rst` pulse. It stays 1 after that, even when the manager becomes healthy again.
- R7: While `rst_n` is 0, `mgr_rst` and `reset_seen` are 0. Counting restarts from zero once `rst_n` is released.
- R8: If health returns during a pulse, `mgr_rst` drops to 0 no later than the fourth edge after the input change and stays 0 while health holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Constant reference clock, not taken from any clock-manager output |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_in | input | 1 | Lock status from the clock manager, asynchronous |
| clk_ok_in | input | 1 | Input-clock-present status from the clock manager, asynchronous |
| mgr_rst | output | 1 | Active-high reset to the clock manager |
| reset_seen | output | 1 | Sticky flag: at least one recovery reset has been issued |

## Verification
The bench uses a small counter so that it can measure the exact edge on which the first pulse appears, the pulse width and the spacing between pulses. A comparison off by one, or a counter that saturates instead of wrapping, would move the first edge, change the width, or stop the second pulse from appearing. It drives lock-only and clock-present-only cases separately, which catches a gate that uses OR where AND is needed. It measures the delay from loss of lock to the first pulse, which exposes a missing or extra synchronizer stage. It also restores health in the middle of a pulse to check that the pulse ends promptly while the sticky flag is kept, and that only `rst_n` clears that flag.

// File: rtl/lw_pkg.sv
`timescale 1ns/1ps
// Package: shared helpers for the lock watchdog.
// Assumes widths below 31 bits so that integer arithmetic does not overflow.
package lw_pkg;

    // Returns the first counter value at which the manager reset fires.
    function automatic int unsigned fire_start(input int unsigned width, input int unsigned span);
        return (32'd1 << width) - span;
    endfunction

endpackage

// File: rtl/lw_sync.sv
`timescale 1ns/1ps
// Module: lw_sync
// Brings N asynchronous status bits into the reference domain through two flops each.
// Assumes the inputs are level signals that stay stable for several reference cycles.
module lw_sync #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_async,
    output logic [N-1:0] q_sync
);

    for (genvar gi = 0; gi < N; gi++) begin : g_bit
        logic meta_q;
        logic stab_q;

        // Two-stage capture of one status bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= d_async[gi];
                stab_q <= meta_q;
            end
        end

        assign q_sync[gi] = stab_q;
    end

endmodule

// File: rtl/lw_counter.sv
`timescale 1ns/1ps
// Module: lw_counter
// Free-running up-counter that is cleared while the manager is healthy.
// It wraps at its maximum value, so reset attempts repeat.
// Assumes healthy is already synchronous to clk.
module lw_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             healthy,
    output logic [CNT_W-1:0] cnt
);

    // Clear while healthy; otherwise count up with modular wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (healthy) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/lw_pulse.sv
`timescale 1ns/1ps
// Module: lw_pulse
// Decodes the top RST_CYC counter values into a registered manager reset,
// and keeps a sticky record that a reset was issued.
// Assumes RST_CYC is at least 1 and less than 2**CNT_W.
module lw_pulse #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned RST_CYC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    output logic             rst_out,
    output logic             seen
);

    localparam logic [CNT_W-1:0] FIRE_AT = CNT_W'(lw_pkg::fire_start(CNT_W, RST_CYC));

    logic fire;

    // Window decode: true in the top RST_CYC counter values.
    always_comb begin
        fire = (cnt >= FIRE_AT);
    end

    // Register the reset output and the sticky flag so the output cannot glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_out <= 1'b0;
            seen    <= 1'b0;
        end else begin
            rst_out <= fire;
            seen    <= seen | fire;
        end
    end

endmodule

// File: rtl/clkmgr_lock_watchdog.sv
`timescale 1ns/1ps
// Module: clkmgr_lock_watchdog
// Watchdog that resets a clock manager again and again until it reports lock
// with its input clock present. Everything runs on clk_ref, which must be
// a constant clock that does not come from the manager being watched.
// Assumes 2**CNT_W reference cycles is longer than the manager's worst lock
// time, and RST_CYC reference cycles cover at least 3 manager input cycles.
module clkmgr_lock_watchdog #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned RST_CYC = 8
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic lock_in,
    input  logic clk_ok_in,
    output logic mgr_rst,
    output logic reset_seen
);

    logic [1:0]       stat_sync;
    logic             healthy;
    logic [CNT_W-1:0] cnt;

    lw_sync #(.N(2)) u_sync (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .d_async ({clk_ok_in, lock_in}),
        .q_sync  (stat_sync)
    );

    // Healthy only when lock and input-clock-present are both good.
    always_comb begin
        healthy = stat_sync[0] & stat_sync[1];
    end

    lw_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .healthy (healthy),
        .cnt     (cnt)
    );

    lw_pulse #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_pulse (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .cnt     (cnt),
        .rst_out (mgr_rst),
        .seen    (reset_seen)
    );

endmodule

// File: rtl/lw_watchdog_checker.sv
`timescale 1ns/1ps
// Module: lw_watchdog_checker
// Property checks for clkmgr_lock_watchdog, attached with bind.
module lw_watchdog_checker #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned RST_CYC = 8
) (
    input logic             clk_ref,
    input logic             rst_n,
    input logic             healthy,
    input logic [CNT_W-1:0] cnt,
    input logic             mgr_rst,
    input logic             reset_seen
);

    localparam logic [CNT_W-1:0] FIRE_AT = CNT_W'(lw_pkg::fire_start(CNT_W, RST_CYC));

    p_hold_zero_r1: assert property (@(posedge clk_ref) disable iff (!rst_n)
        healthy |=> (cnt == '0));

    p_count_up_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !healthy |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    p_fire_start_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(mgr_rst) |-> ($past(cnt) == FIRE_AT));

    p_wrap_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (!healthy && (cnt == '1)) |=> (cnt == '0));

    p_sticky_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        reset_seen |=> reset_seen);

    p_seen_with_rst_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        mgr_rst |-> reset_seen);

endmodule

bind clkmgr_lock_watchdog lw_watchdog_checker #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_chk (
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .healthy    (healthy),
    .cnt        (cnt),
    .mgr_rst    (mgr_rst),
    .reset_seen (reset_seen)
);

// File: tb/clkmgr_lock_watchdog_bench.sv
`timescale 1ns/1ps
// Bench for clkmgr_lock_watchdog. It uses CNT_W=5 and RST_CYC=4:
// the period is 32, and the first high sample falls 29 edges after counting starts.
module clkmgr_lock_watchdog_bench;

    localparam int unsigned W   = 5;
    localparam int unsigned R   = 4;
    localparam int unsigned PER = 1 << W;
    localparam int unsigned FIRST = PER - R + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lock_in = 1'b0;
    logic clk_ok_in = 1'b0;
    logic mgr_rst;
    logic reset_seen;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    clkmgr_lock_watchdog #(.CNT_W(W), .RST_CYC(R)) u_clkmgr_lock_watchdog (
        .clk_ref    (clk),
        .rst_n      (rst_n),
        .lock_in    (lock_in),
        .clk_ok_in  (clk_ok_in),
        .mgr_rst    (mgr_rst),
        .reset_seen (reset_seen)
    );

    typedef struct packed {
        logic        lk;
        logic        ok;
        logic [15:0] edges;
        logic        e_rst;
        logic        e_seen;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 16'd28,  1'b0, 1'b0},
        '{1'b0, 1'b0, 16'd29,  1'b1, 1'b1},
        '{1'b0, 1'b0, 16'd32,  1'b1, 1'b1},
        '{1'b0, 1'b0, 16'd33,  1'b0, 1'b1},
        '{1'b1, 1'b0, 16'd29,  1'b1, 1'b1},
        '{1'b0, 1'b1, 16'd30,  1'b1, 1'b1},
        '{1'b1, 1'b0, 16'd61,  1'b1, 1'b1},
        '{1'b0, 1'b1, 16'd65,  1'b0, 1'b1},
        '{1'b1, 1'b1, 16'd29,  1'b0, 1'b0},
        '{1'b1, 1'b1, 16'd200, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Apply reset with the given status inputs, then release it at a falling edge.
    task automatic do_reset(input logic lk, input logic ok);
        @(negedge clk);
        rst_n = 1'b0;
        lock_in = lk;
        clk_ok_in = ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int rises;
        int highs;
        int first_rise;
        int second_rise;
        int wait_n;
        logic prev;

        // R7: outputs are held low while in reset.
        do_reset(1'b0, 1'b0);
        rst_n = 1'b0;
        edges(2);
        check("R7 reset mgr_rst", mgr_rst, 1'b0);
        check("R7 reset reset_seen", reset_seen, 1'b0);
        rst_n = 1'b1;

        // Vector table covering R1, R2, R3, R4 and R6.
        for (int i = 0; i < NV; i++) begin
            do_reset(VECS[i].lk, VECS[i].ok);
            edges(int'(VECS[i].edges));
            check($sformatf("R1/R2/R3/R4 vec%0d mgr_rst", i), mgr_rst, VECS[i].e_rst);
            check($sformatf("R6 vec%0d reset_seen", i), reset_seen, VECS[i].e_seen);
        end

        // R3 and R4: measure where pulses start, their width and their repeat period.
        do_reset(1'b0, 1'b0);
        rises = 0; highs = 0; first_rise = -1; second_rise = -1; prev = 1'b0;
        for (int k = 1; k <= 100; k++) begin
            edges(1);
            if (mgr_rst) highs++;
            if (mgr_rst && !prev) begin
                rises++;
                if (first_rise < 0) first_rise = k;
                else if (second_rise < 0) second_rise = k;
            end
            prev = mgr_rst;
        end
        check_int("R3 first pulse edge", first_rise, FIRST);
        check_int("R4 second pulse edge", second_rise, FIRST + PER);
        check_int("R3/R4 high cycles in 100", highs, 3 * R);
        check_int("R4 pulse count in 100", rises, 3);

        // R1: a long healthy stretch issues no reset.
        do_reset(1'b1, 1'b1);
        highs = 0;
        for (int k = 0; k < 150; k++) begin
            edges(1);
            if (mgr_rst) highs++;
        end
        check_int("R1 healthy hold highs", highs, 0);
        check("R1 healthy reset_seen", reset_seen, 1'b0);

        // R5: latency from loss of lock to the first pulse.
        lock_in = 1'b0;
        wait_n = 0;
        while (!mgr_rst && wait_n < 200) begin
            edges(1);
            wait_n++;
        end
        check_int("R5 lock-loss to pulse edges", wait_n, FIRST + 2);

        // R8: health returns mid-pulse; the pulse ends by the fourth edge.
        lock_in = 1'b1;
        edges(4);
        check("R8 pulse ends after recovery", mgr_rst, 1'b0);
        highs = 0;
        for (int k = 0; k < 60; k++) begin
            edges(1);
            if (mgr_rst) highs++;
        end
        check_int("R8 no further pulses", highs, 0);
        check("R6 sticky after recovery", reset_seen, 1'b1);

        // R7: only rst_n clears the sticky flag.
        do_reset(1'b1, 1'b1);
        edges(1);
        check("R7 sticky cleared by reset", reset_seen, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule